// File: doc/BRIEF.md
# Per-Stage Load-Enable Stall Control

This block drives the hold and advance decisions of a four-stage in-order pipeline whose stages are, from first to last, IF, ALU, MEM and WB. Each stage has one load-enable output. A stall source never names its event. It names the deepest stage that must not advance, and the block clears the enable of that stage and of every stage in front of it. Several sources may stall at once. Their hold masks are merged by a plain OR, so the source that freezes the most stages decides the outcome without any priority encoder.

The same block holds the per-stage valid, PC and instruction registers that these enables gate, and those PC registers form the PC queue. A stage that is enabled while its predecessor is held takes a bubble. An instruction retires only when it leaves WB, so WB is the single commit point. Fetch presents a new instruction, with its PC and a valid flag, every cycle. The block accepts it whenever IF is enabled.

Top module: `pipe_hold_ctrl`

## Requirements
- R1: Stage indices are encoded as 0 = IF, 1 = ALU, 2 = MEM and 3 = WB, and bit s of `load_en` belongs to stage s. A single source with `req_vld[i]` high and stage index k in `req_stage[2*i+1:2*i]` clears `load_en[k:0]` and leaves every higher bit set. The stage index of a source whose `req_vld` bit is low has no effect.
- R2: When several sources request at once, `load_en` equals the result of the request that names the deepest stage. The cleared bits are the OR of the individual masks.
- R3: With no request active, all four bits of `load_en` are 1.
- R4: A stage whose enable is 0 keeps its valid bit, PC and instruction unchanged across the clock edge.
- R5: A stage s above 0 whose own enable and whose predecessor's enable are both 1 takes the predecessor's valid bit, PC and instruction at the next edge. IF, when enabled, takes `fetch_vld`, `fetch_pc` and `fetch_instr`. `fetch_take` equals `load_en[0]`.
- R6: A stage whose enable is 1 while its predecessor's enable is 0 holds a bubble after the edge: its valid bit is 0.
- R7: `commit_vld` is high exactly when WB holds a valid instruction and `load_en[3]` is 1, and `commit_pc` and `commit_instr` then show that instruction. Every accepted fetch commits once, in fetch order.
- R8: A synchronous active-low reset clears every stage valid bit, so no commit happens in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | N_SRC | Stall request active, one bit per source |
| req_stage | input | 2*N_SRC | Deepest stage to hold, per source |
| fetch_vld | input | 1 | Fetch presents a valid instruction |
| fetch_pc | input | AW | PC of the fetched instruction |
| fetch_instr | input | IW | Fetched instruction word |
| fetch_take | output | 1 | IF accepts the fetch input this cycle |
| load_en | output | 4 | Per-stage load enables, bit 0 = IF |
| stage_vld | output | 4 | Valid bit of each stage register |
| stage_pc | output | 4*AW | PC of each stage, stage s at bits s*AW upward |
| stage_instr | output | 4*IW | Instruction of each stage, stage s at bits s*IW upward |
| commit_vld | output | 1 | Instruction in WB retires this cycle |
| commit_pc | output | AW | PC of the retiring instruction |
| commit_instr | output | IW | Word of the retiring instruction |

## Verification
If the hold mask is merged wrongly, `load_en` shows it in the same cycle as the requests, before any clock edge. If a stage register holds, copies or bubbles wrongly, `stage_vld`, `stage_pc` and `stage_instr` differ from the bench model one cycle later. Lost, duplicated or reordered instructions also show at the commit outputs once the damaged slot reaches WB. That takes at most four cycles, plus the stall cycles on the way. Random requests from several sources at once are mixed with directed cases: one source alone, every source on WB, and no source at all.

// File: rtl/pipe_hold_pkg.sv
// Package: shared stage encoding and the thermometer expansion of a
// requested stage index. Assumes a four-stage in-order pipeline.
package pipe_hold_pkg;
    localparam int NUM_STG   = 4;
    localparam int STG_IDX_W = $clog2(NUM_STG);

    typedef enum logic [STG_IDX_W-1:0] {
        STG_IF  = 2'd0,
        STG_ALU = 2'd1,
        STG_MEM = 2'd2,
        STG_WB  = 2'd3
    } stage_e;

    // Hold mask covering the named stage and every earlier stage.
    function automatic logic [NUM_STG-1:0] thermo(input logic [STG_IDX_W-1:0] idx);
        logic [NUM_STG-1:0] m;
        for (int s = 0; s < NUM_STG; s++) begin
            m[s] = (s <= int'(idx));
        end
        return m;
    endfunction
endpackage

// File: rtl/hold_mask_gen.sv
// hold_mask_gen: turns each source's (valid, stage index) request into a
// per-stage hold mask. Assumes a source names at most one stage per cycle.
module hold_mask_gen
    import pipe_hold_pkg::*;
#(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0]           req_vld,
    input  logic [N_SRC*STG_IDX_W-1:0] req_stage,
    output logic [N_SRC*NUM_STG-1:0]   src_mask
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        // Expand one source's index; an idle source contributes nothing.
        assign src_mask[i*NUM_STG +: NUM_STG] =
            req_vld[i] ? thermo(req_stage[i*STG_IDX_W +: STG_IDX_W]) : '0;
    end
endmodule

// File: rtl/hold_merge.sv
// hold_merge: ORs all source masks and inverts the result into the stage
// load enables. Assumes masks are thermometer codes, so the output is too.
module hold_merge
    import pipe_hold_pkg::*;
#(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC*NUM_STG-1:0] src_mask,
    output logic [NUM_STG-1:0]       load_en
);
    logic [NUM_STG-1:0] hold;

    // Wired-OR equivalent: any source clearing a stage holds it.
    always_comb begin
        hold = '0;
        for (int i = 0; i < N_SRC; i++) begin
            hold = hold | src_mask[i*NUM_STG +: NUM_STG];
        end
        load_en = ~hold;
    end
endmodule

// File: rtl/pipe_stage_reg.sv
// pipe_stage_reg: one stage's valid/PC/instruction register. It holds when
// its own enable is low, bubbles when only its predecessor is held, and
// copies otherwise. Assumes the enables are thermometer coded.
module pipe_stage_reg #(
    parameter int AW = 32,
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_self,
    input  logic          load_prev,
    input  logic          in_vld,
    input  logic [AW-1:0] in_pc,
    input  logic [IW-1:0] in_instr,
    output logic          out_vld,
    output logic [AW-1:0] out_pc,
    output logic [IW-1:0] out_instr
);
    // Valid bit: hold, bubble or take the predecessor's valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
        end else if (load_self) begin
            out_vld <= load_prev & in_vld;
        end
    end

    // Payload: only moves when a real transfer happens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pc    <= '0;
            out_instr <= '0;
        end else if (load_self && load_prev) begin
            out_pc    <= in_pc;
            out_instr <= in_instr;
        end
    end
endmodule

// File: rtl/pipe_hold_ctrl.sv
// pipe_hold_ctrl: distributed stall control for a four-stage in-order
// pipeline plus the stage registers it gates. Each source asks to hold a
// stage and everything before it; the merged enables drive the registers.
// Assumes the fetch side keeps its input stable until fetch_take is high.
module pipe_hold_ctrl
    import pipe_hold_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter int AW    = 32,
    parameter int IW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           req_vld,
    input  logic [N_SRC*STG_IDX_W-1:0] req_stage,
    input  logic                       fetch_vld,
    input  logic [AW-1:0]              fetch_pc,
    input  logic [IW-1:0]              fetch_instr,
    output logic                       fetch_take,
    output logic [NUM_STG-1:0]         load_en,
    output logic [NUM_STG-1:0]         stage_vld,
    output logic [NUM_STG*AW-1:0]      stage_pc,
    output logic [NUM_STG*IW-1:0]      stage_instr,
    output logic                       commit_vld,
    output logic [AW-1:0]              commit_pc,
    output logic [IW-1:0]              commit_instr
);
    localparam int LAST = NUM_STG - 1;

    logic [N_SRC*NUM_STG-1:0] src_mask;

    hold_mask_gen #(.N_SRC(N_SRC)) u_mask (
        .req_vld   (req_vld),
        .req_stage (req_stage),
        .src_mask  (src_mask)
    );

    hold_merge #(.N_SRC(N_SRC)) u_merge (
        .src_mask (src_mask),
        .load_en  (load_en)
    );

    for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
        if (s == 0) begin : g_first
            pipe_stage_reg #(.AW(AW), .IW(IW)) u_reg (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_self (load_en[0]),
                .load_prev (1'b1),
                .in_vld    (fetch_vld),
                .in_pc     (fetch_pc),
                .in_instr  (fetch_instr),
                .out_vld   (stage_vld[0]),
                .out_pc    (stage_pc[0 +: AW]),
                .out_instr (stage_instr[0 +: IW])
            );
        end else begin : g_next
            pipe_stage_reg #(.AW(AW), .IW(IW)) u_reg (
                .clk       (clk),
                .rst_n     (rst_n),
                .load_self (load_en[s]),
                .load_prev (load_en[s-1]),
                .in_vld    (stage_vld[s-1]),
                .in_pc     (stage_pc[(s-1)*AW +: AW]),
                .in_instr  (stage_instr[(s-1)*IW +: IW]),
                .out_vld   (stage_vld[s]),
                .out_pc    (stage_pc[s*AW +: AW]),
                .out_instr (stage_instr[s*IW +: IW])
            );
        end
    end

    // Retirement: the instruction in the last stage leaves when it may load.
    always_comb begin
        commit_vld   = stage_vld[LAST] & load_en[LAST];
        commit_pc    = stage_pc[LAST*AW +: AW];
        commit_instr = stage_instr[LAST*IW +: IW];
        fetch_take   = load_en[0];
    end
endmodule

// File: rtl/pipe_hold_ctrl_chk.sv
// pipe_hold_ctrl_chk: protocol checker bound to pipe_hold_ctrl. Assumes the
// stage index encoding of pipe_hold_pkg.
module pipe_hold_ctrl_chk
    import pipe_hold_pkg::*;
#(
    parameter int N_SRC = 3,
    parameter int AW    = 32,
    parameter int IW    = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_SRC-1:0]           req_vld,
    input logic [N_SRC*STG_IDX_W-1:0] req_stage,
    input logic                       fetch_vld,
    input logic [AW-1:0]              fetch_pc,
    input logic [NUM_STG-1:0]         load_en,
    input logic [NUM_STG-1:0]         stage_vld,
    input logic [NUM_STG*AW-1:0]      stage_pc,
    input logic                       commit_vld
);
    int   deep;
    logic any_req;

    // Deepest requested stage, found by maximum rather than by OR.
    always_comb begin
        deep    = 0;
        any_req = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_vld[i]) begin
                any_req = 1'b1;
                if (int'(req_stage[i*STG_IDX_W +: STG_IDX_W]) > deep) begin
                    deep = int'(req_stage[i*STG_IDX_W +: STG_IDX_W]);
                end
            end
        end
    end

    // R1
    deep_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> !load_en[deep]);

    // R2
    above_deep_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && deep < NUM_STG-1) |-> load_en[NUM_STG-1]);

    // R3
    idle_all_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |-> (load_en == '1));

    // R5
    fetch_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en[0] |=> (stage_vld[0] == $past(fetch_vld)) &&
                       (!stage_vld[0] || stage_pc[0 +: AW] == $past(fetch_pc)));

    // R7
    no_commit_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en[NUM_STG-1] |-> !commit_vld);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (stage_vld == '0));

    for (genvar s = 1; s < NUM_STG; s++) begin : g_stg
        // R4
        hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load_en[s] |=> $stable(stage_vld[s]) && $stable(stage_pc[s*AW +: AW]));

        // R5
        advance_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_en[s] && load_en[s-1]) |=>
                (stage_vld[s] == $past(stage_vld[s-1])) &&
                (stage_pc[s*AW +: AW] == $past(stage_pc[(s-1)*AW +: AW])));

        // R6
        bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_en[s] && !load_en[s-1]) |=> !stage_vld[s]);
    end
endmodule

bind pipe_hold_ctrl pipe_hold_ctrl_chk #(.N_SRC(N_SRC), .AW(AW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_vld    (req_vld),
    .req_stage  (req_stage),
    .fetch_vld  (fetch_vld),
    .fetch_pc   (fetch_pc),
    .load_en    (load_en),
    .stage_vld  (stage_vld),
    .stage_pc   (stage_pc),
    .commit_vld (commit_vld)
);

// File: tb/pipe_hold_ctrl_tb.sv
// Bench: directed and seeded random stall requests against a cycle model
// of the four stage registers and an in-order commit scoreboard.
module pipe_hold_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 3;
    localparam int AW = 32;
    localparam int IW = 32;
    localparam int NS = 4;
    localparam logic [IW-1:0] INS_KEY = 32'h5A3C_0000;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [N_SRC-1:0]    req_vld;
    logic [N_SRC*2-1:0]  req_stage;
    logic                fetch_vld;
    logic [AW-1:0]       fetch_pc;
    logic [IW-1:0]       fetch_instr;
    logic                fetch_take;
    logic [NS-1:0]       load_en;
    logic [NS-1:0]       stage_vld;
    logic [NS*AW-1:0]    stage_pc;
    logic [NS*IW-1:0]    stage_instr;
    logic                commit_vld;
    logic [AW-1:0]       commit_pc;
    logic [IW-1:0]       commit_instr;

    pipe_hold_ctrl #(.N_SRC(N_SRC), .AW(AW), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_stage(req_stage),
        .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .fetch_instr(fetch_instr),
        .fetch_take(fetch_take), .load_en(load_en), .stage_vld(stage_vld),
        .stage_pc(stage_pc), .stage_instr(stage_instr), .commit_vld(commit_vld),
        .commit_pc(commit_pc), .commit_instr(commit_instr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic          m_vld [NS];
    logic [AW-1:0] m_pc  [NS];
    string         m_tag [NS];
    logic [AW-1:0] next_fpc = 32'h0000_1000;
    logic [AW-1:0] exp_commit_pc = 32'h0000_1000;
    int            n_fetched = 0;
    int            n_commit = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected enables: every active source clears its stage and all before it.
    function automatic logic [NS-1:0] exp_enables(input logic [N_SRC-1:0] rv,
                                                  input logic [N_SRC*2-1:0] rs);
        logic [NS-1:0] held = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (rv[i]) begin
                for (int s = 0; s < NS; s++) begin
                    if (s <= int'(rs[i*2 +: 2])) held[s] = 1'b1;
                end
            end
        end
        return ~held;
    endfunction

    // One cycle: drive, check combinational and registered outputs, update model.
    task automatic step(input logic [N_SRC-1:0] rv, input logic [N_SRC*2-1:0] rs,
                        input logic fv);
        logic [NS-1:0] en;
        int nact;
        string etag;
        @(negedge clk);
        req_vld     = rv;
        req_stage   = rs;
        fetch_vld   = fv;
        fetch_pc    = next_fpc;
        fetch_instr = next_fpc ^ INS_KEY;
        #1;
        en = exp_enables(rv, rs);
        nact = $countones(rv);
        etag = (nact == 0) ? "R3" : (nact == 1) ? "R1" : "R2";
        chk(load_en == en, etag, "load_en", 64'(load_en), 64'(en));
        chk(fetch_take == en[0], "R5", "fetch_take", 64'(fetch_take), 64'(en[0]));
        for (int s = 0; s < NS; s++) begin
            chk(stage_vld[s] == m_vld[s], m_tag[s], $sformatf("stage %0d valid", s),
                64'(stage_vld[s]), 64'(m_vld[s]));
            if (m_vld[s]) begin
                chk(stage_pc[s*AW +: AW] == m_pc[s], m_tag[s],
                    $sformatf("stage %0d pc", s), 64'(stage_pc[s*AW +: AW]), 64'(m_pc[s]));
                chk(stage_instr[s*IW +: IW] == (m_pc[s] ^ INS_KEY), m_tag[s],
                    $sformatf("stage %0d instr", s), 64'(stage_instr[s*IW +: IW]),
                    64'(m_pc[s] ^ INS_KEY));
            end
        end
        // R7: commit presence and in-order identity
        chk(commit_vld == (m_vld[NS-1] & en[NS-1]), "R7", "commit_vld",
            64'(commit_vld), 64'(m_vld[NS-1] & en[NS-1]));
        if (commit_vld) begin
            chk(commit_pc == exp_commit_pc, "R7", "commit order pc",
                64'(commit_pc), 64'(exp_commit_pc));
            chk(commit_instr == (exp_commit_pc ^ INS_KEY), "R7", "commit instr",
                64'(commit_instr), 64'(exp_commit_pc ^ INS_KEY));
            exp_commit_pc = exp_commit_pc + 4;
            n_commit++;
        end
        // Model update for the coming edge, last stage first.
        for (int s = NS-1; s >= 1; s--) begin
            if (!en[s]) begin
                m_tag[s] = "R4";
            end else if (!en[s-1]) begin
                m_vld[s] = 1'b0;
                m_tag[s] = "R6";
            end else begin
                m_vld[s] = m_vld[s-1];
                m_pc[s]  = m_pc[s-1];
                m_tag[s] = "R5";
            end
        end
        if (en[0]) begin
            m_vld[0] = fv;
            m_pc[0]  = next_fpc;
            m_tag[0] = "R5";
            if (fv) begin
                next_fpc = next_fpc + 4;
                n_fetched++;
            end
        end else begin
            m_tag[0] = "R4";
        end
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        req_vld = '0;
        req_stage = '0;
        fetch_vld = 1'b0;
        fetch_pc = '0;
        fetch_instr = '0;
        for (int s = 0; s < NS; s++) begin
            m_vld[s] = 1'b0;
            m_pc[s]  = '0;
            m_tag[s] = "R8";
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk(stage_vld == '0, "R8", "stage_vld after reset", 64'(stage_vld), 64'd0);
        chk(commit_vld == 1'b0, "R8", "commit after reset", 64'(commit_vld), 64'd0);
        rst_n = 1'b1;

        // Directed: idle flow (R3), single sources (R1), ignored index (R1)
        repeat (6) step('0, 6'b11_10_01, 1'b1);
        step(3'b001, 6'b00_00_00, 1'b1);
        step(3'b010, 6'b00_11_00, 1'b1);
        step(3'b100, 6'b01_00_00, 1'b1);
        step(3'b001, 6'b11_11_10, 1'b1);
        // Directed: mixed depths (R2), full freeze then release (R4, R6)
        step(3'b111, 6'b00_10_01, 1'b1);
        repeat (4) step(3'b111, 6'b11_11_11, 1'b1);
        step(3'b011, 6'b00_00_11, 1'b0);
        step(3'b100, 6'b10_00_00, 1'b1);
        repeat (4) step('0, '0, 1'b1);

        // Seeded random simultaneous requests
        for (int n = 0; n < 4000; n++) begin
            logic [N_SRC-1:0] rv;
            logic [N_SRC*2-1:0] rs;
            for (int i = 0; i < N_SRC; i++) begin
                rv[i] = ($urandom_range(0, 9) < 2);
                rs[i*2 +: 2] = 2'($urandom_range(0, 3));
            end
            step(rv, rs, ($urandom_range(0, 9) < 8));
        end

        // Drain: every accepted fetch must have committed exactly once (R7)
        repeat (8) step('0, '0, 1'b0);
        chk(n_commit == n_fetched, "R7", "commits vs fetches",
            64'(n_commit), 64'(n_fetched));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule